// File: doc/BRIEF.md
# CCD Window Readout Sequencer

This block produces the digital timing for reading a frame-transfer CCD. A host loads a small register bank: the frame period, the integration time, an operating mode, and the start row, start column, height and width of a rectangular window. Once running, the block periodically moves the image area into the storage area. It then walks the storage area line by line and emits vertical and horizontal shift strobes, a sample strobe and the coordinates of each pixel it samples.

There are two modes. In whole-frame mode every pixel of every line is sampled. In window mode, lines outside the window and pixels outside it on window lines are dumped with single-cycle shifts and never sampled. Pixels inside the window get a slow four-phase treatment: reset, settle, sample, shift. After the window, the remaining lines are flushed, so the storage area is empty before the next transfer.

Geometry and mode writes land in a shadow set and are copied into the working set only when a transfer starts. The host can therefore retarget the window at any time during a frame without producing a frame with mixed geometry. A window that reaches past the sensor edge is trimmed to the sensor, and a status output reports the trim.

Top module: `ccd_roi_seq`

## Requirements
- R1: After reset, `xfer_o`, `vclk_o`, `hclk_o`, `sample_o` and `clipped_o` are low, and no transfer starts while the run bit is clear.
- R2: Each frame transfer asserts `xfer_o` for exactly ROWS consecutive cycles. No vertical shift, horizontal shift or sample strobe is asserted during a transfer.
- R3: The frame period is written at address 0 and the integration time at address 1. The distance from one transfer start to the next is max(PERIOD, ROWS+INTEG+1, 2*ROWS + H*(COLS+3*W) + 1), where H and W are the trimmed window height and width.
- R4: A transfer is held off until INTEG cycles have elapsed after the previous transfer ended, even when the frame period has already expired.
- R5: In whole-frame mode (mode register bit 1 clear), every pixel is sampled in row-major order. Consecutive samples on one line are 4 cycles apart, and each sample is followed on the next cycle by a horizontal shift.
- R6: In window mode (mode register bit 1 set), start row, start column, height and width are written at addresses 3, 4, 5 and 6. Only pixels inside the window are sampled, in row-major order. The first sample comes ROWS+row0+col0+3 cycles after the transfer starts.
- R7: A line outside the window gets a vertical shift and no horizontal shift. Every column of a window line gets exactly one horizontal shift, and unwanted pixels take one cycle each. Hence one frame gives H*COLS horizontal shifts.
- R8: Every frame gives exactly ROWS vertical shifts, including the flush of the lines below the window.
- R9: Geometry written while a frame is being read does not affect that frame. It takes effect from the next transfer.
- R10: A window past the sensor edge is trimmed to the sensor, and `clipped_o` is high for frames that used a trimmed window. `clipped_o` changes only when a transfer starts.
- R11: Mode register bit 0 is the run bit (address 2). While it is clear, no new transfer starts and all strobes stay low once the current frame has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | DATA_W | Register write data |
| xfer_o | output | 1 | Image-to-storage transfer strobe, one cycle per line moved |
| vclk_o | output | 1 | Storage-to-serial vertical shift strobe |
| hclk_o | output | 1 | Serial register horizontal shift strobe |
| sample_o | output | 1 | Pixel sample strobe |
| row_o | output | RW | Line index, meaningful with `sample_o` |
| col_o | output | CW | Column index, meaningful with `sample_o` |
| clipped_o | output | 1 | Current frame uses a trimmed window |

## Verification
Whole-frame readout with a long period shows that the period alone sets the frame spacing. A mid-sensor window with a short period shows that readout length sets the spacing and that the dump counts are right. A tiny window with a long integration time shows the integration holdoff winning over an expired frame timer. A geometry rewrite issued during a transfer must leave that frame unchanged and show up in the next one. Windows overhanging the corner, or lying wholly beyond the last line, separate correct trimming from plain truncation.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned REG_CNT = 7;

  // Register indices
  localparam int unsigned ADR_PERIOD = 0;
  localparam int unsigned ADR_INTEG  = 1;
  localparam int unsigned ADR_MODE   = 2;
  localparam int unsigned ADR_ROW0   = 3;
  localparam int unsigned ADR_COL0   = 4;
  localparam int unsigned ADR_NROWS  = 5;
  localparam int unsigned ADR_NCOLS  = 6;

  localparam int unsigned MODE_RUN_BIT = 0;
  localparam int unsigned MODE_WIN_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_VSH,
    ST_PIX
  } rd_state_e;

  typedef enum logic [1:0] {
    PH_RESET,
    PH_SETTLE,
    PH_SAMPLE,
    PH_SHIFT
  } pix_phase_e;

endpackage

// File: rtl/ccd_cfg_bank.sv
module ccd_cfg_bank
  import ccd_seq_pkg::*;
#(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned COLS   = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned RW = $clog2(ROWS + 1),
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] integ_o,
  output logic              run_o,
  output logic [RW-1:0]     row_lo_o,
  output logic [RW-1:0]     row_hi_o,
  output logic [CW-1:0]     col_lo_o,
  output logic [CW-1:0]     col_hi_o,
  output logic              clipped_o
);

  localparam logic [DATA_W:0] ROWS_X = (DATA_W + 1)'(ROWS);
  localparam logic [DATA_W:0] COLS_X = (DATA_W + 1)'(COLS);

  logic [DATA_W-1:0] shadow [REG_CNT];

  // One shadow register per address, each with its own write enable
  for (genvar k = 0; k < REG_CNT; k++) begin : g_shadow
    logic              wr_en;
    logic [DATA_W-1:0] q;
    assign wr_en = we_i && (addr_i == ADDR_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata_i;
    end
    assign shadow[k] = q;
  end

  function automatic logic [DATA_W:0] cap_at(input logic [DATA_W:0] v,
                                             input logic [DATA_W:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  logic [DATA_W:0] r_start_x, r_end_x, c_start_x, c_end_x;
  logic            win_mode, trim;
  logic [RW-1:0]   row_lo_d, row_hi_d, row_lo_q, row_hi_q;
  logic [CW-1:0]   col_lo_d, col_hi_d, col_lo_q, col_hi_q;
  logic            clip_q;

  // Next working set computed from the shadow set
  always_comb begin
    r_start_x = {1'b0, shadow[ADR_ROW0]};
    r_end_x   = r_start_x + {1'b0, shadow[ADR_NROWS]};
    c_start_x = {1'b0, shadow[ADR_COL0]};
    c_end_x   = c_start_x + {1'b0, shadow[ADR_NCOLS]};
    win_mode  = shadow[ADR_MODE][MODE_WIN_BIT];
    trim      = (r_end_x > ROWS_X) || (c_end_x > COLS_X);
    if (win_mode) begin
      row_lo_d = RW'(cap_at(r_start_x, ROWS_X));
      row_hi_d = RW'(cap_at(r_end_x,   ROWS_X));
      col_lo_d = CW'(cap_at(c_start_x, COLS_X));
      col_hi_d = CW'(cap_at(c_end_x,   COLS_X));
    end else begin
      row_lo_d = '0;
      row_hi_d = RW'(ROWS);
      col_lo_d = '0;
      col_hi_d = CW'(COLS);
    end
  end

  // Working set register, enabled only at a transfer start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_lo_q <= '0;
      row_hi_q <= '0;
      col_lo_q <= '0;
      col_hi_q <= '0;
      clip_q   <= 1'b0;
    end else if (load_i) begin
      row_lo_q <= row_lo_d;
      row_hi_q <= row_hi_d;
      col_lo_q <= col_lo_d;
      col_hi_q <= col_hi_d;
      clip_q   <= win_mode && trim;
    end
  end

  assign period_o  = shadow[ADR_PERIOD];
  assign integ_o   = shadow[ADR_INTEG];
  assign run_o     = shadow[ADR_MODE][MODE_RUN_BIT];
  assign row_lo_o  = row_lo_q;
  assign row_hi_o  = row_hi_q;
  assign col_lo_o  = col_lo_q;
  assign col_hi_o  = col_hi_q;
  assign clipped_o = clip_q;

endmodule

// File: rtl/ccd_frame_timer.sv
module ccd_frame_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] integ_i,
  input  logic             start_i,
  input  logic             xfer_i,
  output logic             due_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] int_q, int_d;

  always_comb begin
    // Period: counts from the cycle a transfer is launched
    if (start_i)              per_d = CNT_W'(1);
    else if (per_q != CNT_MAX) per_d = per_q + CNT_W'(1);
    else                      per_d = per_q;
    // Integration: counts from the end of the transfer
    if (xfer_i)               int_d = '0;
    else if (int_q != CNT_MAX) int_d = int_q + CNT_W'(1);
    else                      int_d = int_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      int_q <= '0;
    end else begin
      per_q <= per_d;
      int_q <= int_d;
    end
  end

  assign due_o = (per_q >= period_i) && (int_q >= integ_i);

endmodule

// File: rtl/ccd_readout_fsm.sv
module ccd_readout_fsm
  import ccd_seq_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned RW = $clog2(ROWS + 1),
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [RW-1:0] row_lo_i,
  input  logic [RW-1:0] row_hi_i,
  input  logic [CW-1:0] col_lo_i,
  input  logic [CW-1:0] col_hi_i,
  output logic          idle_o,
  output logic          xfer_o,
  output logic          vclk_o,
  output logic          hclk_o,
  output logic          sample_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o
);

  rd_state_e  state_q, state_d;
  pix_phase_e ph_q, ph_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic in_rows, in_cols, last_row, last_col, pix_done;

  assign in_rows  = (row_q >= row_lo_i) && (row_q < row_hi_i);
  assign in_cols  = (col_q >= col_lo_i) && (col_q < col_hi_i);
  assign last_row = (row_q == RW'(ROWS - 1));
  assign last_col = (col_q == CW'(COLS - 1));

  always_comb begin
    state_d  = state_q;
    ph_d     = ph_q;
    row_d    = row_q;
    col_d    = col_q;
    xfer_o   = 1'b0;
    vclk_o   = 1'b0;
    hclk_o   = 1'b0;
    sample_o = 1'b0;
    pix_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_XFER;
          row_d   = '0;
        end
      end
      ST_XFER: begin
        xfer_o = 1'b1;
        if (last_row) begin
          state_d = ST_VSH;
          row_d   = '0;
        end else begin
          row_d = row_q + RW'(1);
        end
      end
      ST_VSH: begin
        vclk_o = 1'b1;
        if (in_rows) begin
          state_d = ST_PIX;
          col_d   = '0;
          ph_d    = PH_RESET;
        end else if (last_row) begin
          state_d = ST_IDLE;
        end else begin
          row_d = row_q + RW'(1);
        end
      end
      ST_PIX: begin
        if (!in_cols) begin
          // Unwanted pixel: a single fast dump shift
          hclk_o   = 1'b1;
          pix_done = 1'b1;
        end else begin
          case (ph_q)
            PH_RESET:  ph_d = PH_SETTLE;
            PH_SETTLE: ph_d = PH_SAMPLE;
            PH_SAMPLE: begin
              sample_o = 1'b1;
              ph_d     = PH_SHIFT;
            end
            default: begin
              hclk_o   = 1'b1;
              pix_done = 1'b1;
            end
          endcase
        end
        if (pix_done) begin
          ph_d = PH_RESET;
          if (last_col) begin
            if (last_row) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_VSH;
              row_d   = row_q + RW'(1);
            end
          end else begin
            col_d = col_q + CW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_RESET;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign row_o  = row_q;
  assign col_o  = col_q;

endmodule

// File: rtl/ccd_roi_seq.sv
module ccd_roi_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned COLS   = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned RW = $clog2(ROWS + 1),
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              xfer_o,
  output logic              vclk_o,
  output logic              hclk_o,
  output logic              sample_o,
  output logic [RW-1:0]     row_o,
  output logic [CW-1:0]     col_o,
  output logic              clipped_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [DATA_W-1:0] period, integ;
  logic              run, due, idle, start;
  logic [RW-1:0]     row_lo, row_hi;
  logic [CW-1:0]     col_lo, col_hi;

  assign start = run && due && idle;

  ccd_cfg_bank #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .DATA_W (DATA_W)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .load_i    (start),
    .period_o  (period),
    .integ_o   (integ),
    .run_o     (run),
    .row_lo_o  (row_lo),
    .row_hi_o  (row_hi),
    .col_lo_o  (col_lo),
    .col_hi_o  (col_hi),
    .clipped_o (clipped_o)
  );

  ccd_frame_timer #(
    .CNT_W (DATA_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .period_i (period),
    .integ_i  (integ),
    .start_i  (start),
    .xfer_i   (xfer_o),
    .due_o    (due)
  );

  ccd_readout_fsm #(
    .ROWS (ROWS),
    .COLS (COLS)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start_i  (start),
    .row_lo_i (row_lo),
    .row_hi_i (row_hi),
    .col_lo_i (col_lo),
    .col_hi_i (col_hi),
    .idle_o   (idle),
    .xfer_o   (xfer_o),
    .vclk_o   (vclk_o),
    .hclk_o   (hclk_o),
    .sample_o (sample_o),
    .row_o    (row_o),
    .col_o    (col_o)
  );

endmodule

// File: rtl/ccd_roi_seq_chk.sv
module ccd_roi_seq_chk #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned RW = $clog2(ROWS + 1),
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_o,
  input logic          vclk_o,
  input logic          hclk_o,
  input logic          sample_o,
  input logic [RW-1:0] row_o,
  input logic [CW-1:0] col_o,
  input logic          clipped_o
);

  logic [15:0] xlen_q, vcnt_q;
  logic        xprev_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlen_q  <= '0;
      vcnt_q  <= '0;
      xprev_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      xprev_q <= xfer_o;
      xlen_q  <= xfer_o ? xlen_q + 16'd1 : 16'd0;
      if (xfer_o && !xprev_q) begin
        vcnt_q <= '0;
        seen_q <= 1'b1;
      end else if (vclk_o) begin
        vcnt_q <= vcnt_q + 16'd1;
      end
    end
  end

  a_r2_xfer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |-> !(vclk_o || hclk_o || sample_o));

  a_r2_xfer_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_o && xprev_q) |-> (xlen_q == 16'(ROWS)));

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_o, vclk_o, hclk_o, sample_o}));

  a_r5_shift_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> (hclk_o && !sample_o));

  a_r8_vclk_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_o && !xprev_q && seen_q) |-> (vcnt_q == 16'(ROWS)));

  a_r10_clip_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clipped_o) |-> (xfer_o && !xprev_q));

  a_r6_coord_range: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> ((row_o < RW'(ROWS)) && (col_o < CW'(COLS))));

endmodule

bind ccd_roi_seq ccd_roi_seq_chk #(
  .ROWS (ROWS),
  .COLS (COLS)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_o    (xfer_o),
  .vclk_o    (vclk_o),
  .hclk_o    (hclk_o),
  .sample_o  (sample_o),
  .row_o     (row_o),
  .col_o     (col_o),
  .clipped_o (clipped_o)
);

// File: tb/test_ccd_roi_seq.sv
module test_ccd_roi_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS + 1);
  localparam int MAXS = 300;

  logic clk;
  logic rst_n;
  logic we;
  logic [2:0] addr;
  logic [15:0] wdata;
  logic xfer, vclk, hclk, sample, clipped;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  int n_chk = 0;
  int n_bad = 0;

  ccd_roi_seq #(.ROWS(ROWS), .COLS(COLS), .DATA_W(16)) i_ccd_roi_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .xfer_o(xfer), .vclk_o(vclk), .hclk_o(hclk),
    .sample_o(sample), .row_o(row), .col_o(col), .clipped_o(clipped));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Frame monitor, sampled away from the active edge
  bit mon_en = 1'b0;
  bit xf_prev = 1'b0;
  int cyc = 0;
  int frame_cnt = 0;
  int cur_start, cur_xlen, cur_v, cur_h, cur_ns, cur_first;
  int cur_r[MAXS], cur_c[MAXS], cur_t[MAXS];
  int last_gap, last_xlen, last_v, last_h, last_ns, last_first;
  int last_r[MAXS], last_c[MAXS], last_t[MAXS];

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (xfer && !xf_prev) begin
        if (frame_cnt > 0) begin
          last_gap = cyc - cur_start;
          last_xlen = cur_xlen; last_v = cur_v; last_h = cur_h;
          last_ns = cur_ns; last_first = cur_first;
          for (int i = 0; i < MAXS; i++) begin
            last_r[i] = cur_r[i]; last_c[i] = cur_c[i]; last_t[i] = cur_t[i];
          end
        end
        cur_start = cyc; cur_xlen = 0; cur_v = 0; cur_h = 0;
        cur_ns = 0; cur_first = -1;
        frame_cnt++;
      end
      if (xfer) cur_xlen++;
      if (vclk) cur_v++;
      if (hclk) cur_h++;
      if (sample) begin
        if (cur_first < 0) cur_first = cyc - cur_start;
        if (cur_ns < MAXS) begin
          cur_r[cur_ns] = int'(row); cur_c[cur_ns] = int'(col); cur_t[cur_ns] = cyc;
        end
        cur_ns++;
      end
      xf_prev = xfer;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_frames(input int k);
    int target;
    target = frame_cnt + k;
    while (frame_cnt < target) @(negedge clk);
  endtask

  task automatic set_geom(input int r0, input int c0, input int h, input int w);
    wr(3, r0); wr(4, c0); wr(5, h); wr(6, w);
  endtask

  // Checks the last completed frame against a window [rlo,rhi) x [clo,chi)
  task automatic check_frame(input string req, input int rlo, input int rhi,
                             input int clo, input int chi, input int gap,
                             input string gap_req, input int first);
    int n, idx, err;
    n = (rhi - rlo) * (chi - clo);
    chk(last_ns == n, {req, " sample count"}, last_ns, n);
    idx = 0; err = 0;
    for (int r = rlo; r < rhi; r++)
      for (int c = clo; c < chi; c++) begin
        if (idx < MAXS && (last_r[idx] != r || last_c[idx] != c)) err++;
        idx++;
      end
    chk(err == 0, {req, " raster order mismatches"}, err, 0);
    chk(last_v == ROWS, "R8 vertical shifts per frame", last_v, ROWS);
    chk(last_h == (rhi - rlo) * COLS, "R7 horizontal shifts per frame",
        last_h, (rhi - rlo) * COLS);
    chk(last_xlen == ROWS, "R2 transfer length", last_xlen, ROWS);
    if (gap >= 0) chk(last_gap == gap, {gap_req, " frame spacing"}, last_gap, gap);
    if (first >= 0) chk(last_first == first, {req, " first sample offset"}, last_first, first);
  endtask

  task automatic t_reset;
    int bad;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (xfer || vclk || hclk || sample || clipped) bad++;
    end
    chk(bad == 0, "R1 outputs low after reset", bad, 0);
    repeat (200) @(negedge clk);
    chk(frame_cnt == 0, "R1 no transfer with run clear", frame_cnt, 0);
  endtask

  task automatic t_full;
    int bad;
    wr(0, 1200); wr(1, 5); wr(2, 1);
    wait_frames(3);
    check_frame("R5", 0, ROWS, 0, COLS, 1200, "R3", ROWS + 3);
    bad = 0;
    for (int i = 1; i < ROWS * COLS; i++)
      if (last_r[i] == last_r[i-1] && last_t[i] - last_t[i-1] != 4) bad++;
    chk(bad == 0, "R5 four-cycle sample pitch", bad, 0);
    chk(clipped == 1'b0, "R10 whole frame not trimmed", clipped, 0);
  endtask

  task automatic t_window;
    set_geom(3, 5, 4, 6);
    wr(0, 100); wr(1, 10); wr(2, 3);
    wait_frames(3);
    check_frame("R6", 3, 7, 5, 11, 2*ROWS + 4*(COLS + 18) + 1, "R3", ROWS + 3 + 5 + 3);
  endtask

  task automatic t_integ;
    set_geom(0, 0, 2, 2);
    wr(0, 50); wr(1, 300);
    wait_frames(3);
    check_frame("R6", 0, 2, 0, 2, ROWS + 300 + 1, "R4", ROWS + 3);
  endtask

  task automatic t_shadow;
    set_geom(1, 1, 2, 3);
    wr(0, 100); wr(1, 0);
    wait_frames(3);
    wait_frames(1);
    repeat (3) @(negedge clk);
    set_geom(8, 2, 3, 4);
    wait_frames(1);
    check_frame("R9 old geometry kept", 1, 3, 1, 4, 100, "R3", ROWS + 1 + 1 + 3);
    wait_frames(1);
    check_frame("R9 new geometry applied", 8, 11, 2, 6, -1, "R3", ROWS + 8 + 2 + 3);
  endtask

  task automatic t_clip;
    set_geom(13, 14, 6, 5);
    wait_frames(3);
    check_frame("R10 corner trim", 13, ROWS, 14, COLS, 100, "R3", ROWS + 13 + 14 + 3);
    chk(clipped == 1'b1, "R10 trim flag set", clipped, 1);
    set_geom(20, 0, 2, 2);
    wait_frames(3);
    check_frame("R10 window below sensor", 0, 0, 0, 2, -1, "R3", -1);
    chk(clipped == 1'b1, "R10 trim flag for off-sensor window", clipped, 1);
    set_geom(2, 2, 2, 2);
    wait_frames(3);
    chk(clipped == 1'b0, "R10 trim flag cleared", clipped, 0);
  endtask

  task automatic t_stop;
    int fc, bad;
    wr(2, 2);
    repeat (2000) @(negedge clk);
    fc = frame_cnt;
    bad = 0;
    repeat (3000) begin
      @(negedge clk);
      if (xfer || vclk || hclk || sample) bad++;
    end
    chk(frame_cnt == fc, "R11 no transfer after run cleared", frame_cnt, fc);
    chk(bad == 0, "R11 strobes quiet while stopped", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frame_cnt, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    t_reset();
    t_full();
    t_window();
    t_integ();
    t_shadow();
    t_clip();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule